// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM command bus. It runs once after every reset and brings the memory from power-up into a known operating state. While reset is held it drives COMMAND INHIBIT. After reset it issues NOP for a programmable settling delay, which is expressed as a clock frequency in MHz times a wait in microseconds. It then precharges all banks and issues two AUTO REFRESH commands. Last, it loads the mode register from a configuration input.

Each step is separated from the next by a parameterized cycle count: precharge recovery, refresh cycle time and mode-register set time. Once the last of these counts has run out, the `init_done` flag rises and stays high until the next reset. From then on the block holds NOP, and the command bus can be handed to the normal scheduler.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_n` is low, {cs_n,ras_n,cas_n,we_n} is 1111 (COMMAND INHIBIT), `addr` and `ba` are zero and `init_done` is 0.
- R2: Let P = CLK_MHZ*POWERUP_US. On the first P rising edges after reset is released, the command is NOP (0111) and `addr` is zero; no other command appears.
- R3: On edge P+1 the command is PRECHARGE (0010) for one cycle, with addr bit 10 = 1 and every other address and bank bit 0.
- R4: The first AUTO REFRESH (0001) is issued T_RP edges after the precharge, and the second T_RFC edges after the first. Each lasts one cycle and has NOP around it.
- R5: LOAD MODE REGISTER (0000) is issued T_RFC edges after the second refresh, for one cycle. addr[9:0] equals `mode_cfg`, addr bits 12..10 are 0 and `ba` is 0.
- R6: `init_done` goes high T_MRD edges after the LOAD MODE edge and stays high until reset.
- R7: Between any two issued commands the bus carries NOP with a zero address.
- R8: Once `init_done` is high, the command stays NOP.
- R9: Asserting reset at any point aborts the sequence, and the next release restarts it from the full power-up delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_cfg | input | MODE_W (10) | Mode word placed on addr[9:0] during LOAD MODE |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ROW_W (13) | Address bus; bit 10 selects all banks on precharge |
| ba | output | BANK_W (2) | Bank address, zero throughout |
| init_done | output | 1 | High from sequence completion until reset |

## Verification
The hardest situation to bring about is a reset that lands partway through the sequence, for example between the two refreshes or in the cycle of the mode load. Recovery from it depends on the counter and the step being reloaded together. The stimulus draws a random abort cycle across the whole sequence length and re-asserts reset there. The next trial then checks every cycle from the start against the expected timeline. The trials also cover `mode_cfg` values of all zeros, all ones and random values, so that every mode bit reaches the address bus.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int CLK_MHZ    = 125,
  parameter int POWERUP_US = 100,
  parameter int T_RP       = 3,
  parameter int T_RFC      = 9,
  parameter int T_MRD      = 2,
  parameter int ROW_W      = 13,
  parameter int BANK_W     = 2,
  parameter int MODE_W     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_cfg,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ROW_W-1:0]  addr,
  output logic [BANK_W-1:0] ba,
  output logic              init_done
);

  localparam int WAIT_CYC = CLK_MHZ * POWERUP_US;
  localparam int MAX_A    = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int MAX_B    = (MAX_A > T_MRD) ? MAX_A : T_MRD;
  localparam int MAX_CNT  = (WAIT_CYC > MAX_B) ? WAIT_CYC : MAX_B;
  localparam int CNT_W    = $clog2(MAX_CNT + 1);

  localparam logic [3:0] CMD_INH = 4'b1111;
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_LMR = 4'b0000;

  typedef enum logic [2:0] {
    ST_WAIT, ST_TRP, ST_TRFC1, ST_TRFC2, ST_TMRD, ST_DONE
  } step_t;

  step_t            st;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       cmd_q;

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_WAIT;
      cnt       <= CNT_W'(WAIT_CYC);
      cmd_q     <= CMD_INH;
      addr      <= '0;
      ba        <= '0;
      init_done <= 1'b0;
    end else begin
      cmd_q <= CMD_NOP;
      addr  <= '0;
      ba    <= '0;
      if (st != ST_DONE && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (st)
          ST_WAIT: begin
            cmd_q    <= CMD_PRE;
            addr[10] <= 1'b1;
            cnt      <= CNT_W'(T_RP - 1);
            st       <= ST_TRP;
          end
          ST_TRP: begin
            cmd_q <= CMD_REF;
            cnt   <= CNT_W'(T_RFC - 1);
            st    <= ST_TRFC1;
          end
          ST_TRFC1: begin
            cmd_q <= CMD_REF;
            cnt   <= CNT_W'(T_RFC - 1);
            st    <= ST_TRFC2;
          end
          ST_TRFC2: begin
            cmd_q <= CMD_LMR;
            addr  <= ROW_W'(mode_cfg);
            cnt   <= CNT_W'(T_MRD - 1);
            st    <= ST_TMRD;
          end
          ST_TMRD: begin
            init_done <= 1'b1;
            st        <= ST_DONE;
          end
          default: st <= ST_DONE;
        endcase
      end
    end
  end

  // R1: reset forces command inhibit on the next edge
  a_r1_inhibit_in_reset: assert property (@(posedge clk)
    !rst_n |=> (cmd_q == CMD_INH && !init_done));

  // R3: a precharge always selects all banks
  a_r3_pre_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q == CMD_PRE |-> (addr[10] && ba == '0));

  // R5: reserved mode bits held low during the load
  a_r5_lmr_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q == CMD_LMR |-> (addr[12:10] == 3'b000 && ba == '0));

  // R6: completion flag is sticky
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R8: nothing but NOP once initialized
  a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> cmd_q == CMD_NOP);

  // R7: no inhibit once out of reset
  a_r7_no_inhibit_running: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cmd_q != CMD_INH);

endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;
  localparam int CLK_MHZ = 2, POWERUP_US = 5, T_RP = 3, T_RFC = 7, T_MRD = 2;
  localparam int P      = CLK_MHZ * POWERUP_US;
  localparam int E_PRE  = P + 1;
  localparam int E_REF1 = E_PRE + T_RP;
  localparam int E_REF2 = E_REF1 + T_RFC;
  localparam int E_LMR  = E_REF2 + T_RFC;
  localparam int E_DONE = E_LMR + T_MRD;

  logic clk = 0, rst_n = 0;
  logic [9:0] mode_cfg = '0;
  logic cs_n, ras_n, cas_n, we_n, init_done;
  logic [12:0] addr;
  logic [1:0] ba;
  int errors = 0, checks = 0;
  bit restarted = 0;

  always #4 clk = ~clk;

  sdram_init_seq #(.CLK_MHZ(CLK_MHZ), .POWERUP_US(POWERUP_US), .T_RP(T_RP),
                   .T_RFC(T_RFC), .T_MRD(T_MRD)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba), .init_done(init_done));

  function automatic logic [3:0] exp_cmd(int k);
    if (k == E_PRE) return 4'b0010;
    if (k == E_REF1 || k == E_REF2) return 4'b0001;
    if (k == E_LMR) return 4'b0000;
    return 4'b0111;
  endfunction

  function automatic logic [12:0] exp_addr(int k, logic [9:0] m);
    if (k == E_PRE) return 13'h0400;
    if (k == E_LMR) return {3'b000, m};
    return '0;
  endfunction

  function automatic string tag_of(int k);
    if (k <= P) return "R2";
    if (k == E_PRE) return "R3";
    if (k == E_REF1 || k == E_REF2) return "R4";
    if (k == E_LMR) return "R5";
    if (k >= E_DONE) return "R6/R8";
    return "R7";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_trial(logic [9:0] m, int stop_at);
    string t;
    @(negedge clk);
    rst_n = 0;
    mode_cfg = m;
    repeat (2) @(negedge clk);
    check("R1 cmd", {cs_n, ras_n, cas_n, we_n}, 4'b1111);
    check("R1 addr/ba/done", {addr, ba, init_done}, '0);
    rst_n = 1;
    for (int k = 1; k <= stop_at; k++) begin
      @(negedge clk);
      t = tag_of(k);
      if (restarted) t = {t, " R9"};
      check({t, " cmd"}, {cs_n, ras_n, cas_n, we_n}, exp_cmd(k));
      check({t, " addr"}, {addr, ba}, {exp_addr(k, m), 2'b00});
      check({t, " done"}, init_done, (k >= E_DONE) ? 1'b1 : 1'b0);
    end
    restarted = (stop_at < E_DONE);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    run_trial(10'h000, E_DONE + 6);
    run_trial(10'h3FF, E_DONE + 6);
    run_trial(10'h155, E_REF1 + 2);
    run_trial(10'h2AA, E_LMR);
    run_trial(10'h0F3, E_DONE + 4);
    for (int i = 0; i < 12; i++) begin
      logic [9:0] m;
      int stop;
      m = 10'($urandom);
      stop = ($urandom % 2) ? E_DONE + 3 : 1 + ($urandom % (E_DONE + 2));
      run_trial(m, stop);
    end
    run_trial(10'h3C5, E_DONE + 8);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule